// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Master

This block runs complete command sequences on a three-wire serial EEPROM that holds 64 words of 16 bits. It drives chip select, serial clock and serial data toward the device and samples the data line that comes back. A client hands over one command at a time: read or write, a 6-bit word address and, for writes, 16 bits of data. The block then produces every pin transition that the command needs and reports completion with a one-cycle `done` pulse.

Each pin step lasts one phase, which is `PHASE_CYC` system clocks. The default is 50 µs at 100 MHz. A read shifts out its opcode and address and then clocks in 16 data bits. It ends with a standby toggle of chip select. A write is wrapped in an enable/disable pair of commands. After the data bits, a standby toggle starts the device's internal programming cycle. The block then polls the returned data line once per phase until it reads high, or until `POLL_MAX` samples have been taken, in which case it raises `timeout`. The write still ends with the disable command and a cleanup pulse. The returned data line passes through a two-flop synchronizer, so `PHASE_CYC` must be at least 3.

Top module: `mw_eeprom_master`

## Requirements
- R1: While reset is held and after it is released, `ee_cs`, `ee_sk`, `ee_di`, `busy`, `done` and `timeout` are all low.
- R2: Bits are sent most significant first. Each bit takes three phases of `PHASE_CYC` clocks: DI takes the bit value with SK low, then SK goes high, then SK goes low. DI never changes while SK is high.
- R3: A command begins with one phase in which SK and DI are low while CS keeps its idle level. The next phase raises CS. DI is low whenever CS rises.
- R4: A read sends opcode 3'b110 and then the 6-bit address. It then takes in 16 bits, MSB first, each sampled at the end of an SK-high phase. It finishes with a standby sequence. `done` rises 65 phases after the accepting clock edge, and `rd_data` holds the word during that cycle.
- R5: DI is low during every input, standby and poll phase, so it returns low after every output phase.
- R6: Standby takes four phases: CS and SK low, then SK high, then CS high, then SK low. CS therefore rises with SK high once per read and three times per write.
- R7: A write is sent in this order: enable (5'b10011 followed by four zero bits), standby, opcode 3'b101 with the address and 16 data bits, standby, poll, standby, disable (5'b10000 followed by four zero bits), cleanup.
- R8: The poll samples the synchronized data line once per phase. The first high sample ends the poll. If sample k is the first high one (k ≤ `POLL_MAX`), the write's `done` rises 146 + k phases after acceptance.
- R9: If none of `POLL_MAX` samples is high, `timeout` is set and the sequence continues, so `done` rises 146 + `POLL_MAX` phases after acceptance. `timeout` stays set until the next command is accepted, which clears it.
- R10: Cleanup drives CS and DI low for one phase and then gives one SK high phase and one SK low phase. After a write, CS stays low in idle.
- R11: A command is accepted only in idle. A `cmd_valid` seen while `busy` is high starts nothing.
- R12: `done` is high for exactly one cycle per accepted command, and `busy` is low on the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 6 | Word address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read word, valid with `done` after a read |
| timeout | output | 1 | Ready poll expired on the last write |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Serial data to the device |
| ee_do | input | 1 | Serial data from the device |

## Verification
Every result is due a whole number of phases after the accepting clock edge. A read completes after 65 phases, and a write after 146 phases plus its poll length. The bench counts clock edges from that edge up to the `done` pulse and compares the count with the phase total times `PHASE_CYC`, plus one. A device model schedules the ready level between two poll samples, half a phase after sample k−1, so the poll length k is fixed by construction and does not depend on edge ordering. Read data, the timeout flag and the device model's command counters are sampled on the `done` cycle. The three cycles after it are checked for a repeated `done` or a lingering `busy`.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;

  localparam int unsigned MW_ADDR_W  = 6;
  localparam int unsigned MW_DATA_W  = 16;
  localparam int unsigned MW_CMD_W   = 3 + MW_ADDR_W;
  localparam int unsigned MW_FRAME_W = MW_CMD_W + MW_DATA_W;
  localparam int unsigned MW_CNT_W   = $clog2(MW_FRAME_W + 1);
  localparam int unsigned MW_SEG_W   = 4;

  localparam logic [2:0] OP_READ  = 3'b110;
  localparam logic [2:0] OP_WRITE = 3'b101;
  localparam logic [4:0] OP_WEN   = 5'b10011;
  localparam logic [4:0] OP_WDIS  = 5'b10000;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_OUT, ST_IN, ST_STBY, ST_POLL, ST_CLEAN, ST_DONE
  } mw_state_e;

  // Segment list of a command: which kind of step runs at position seg.
  function automatic mw_state_e seg_kind(input logic wr, input logic [MW_SEG_W-1:0] seg);
    mw_state_e k;
    if (wr) begin
      case (seg)
        4'd0: k = ST_SETUP;
        4'd1: k = ST_OUT;
        4'd2: k = ST_STBY;
        4'd3: k = ST_OUT;
        4'd4: k = ST_STBY;
        4'd5: k = ST_POLL;
        4'd6: k = ST_STBY;
        4'd7: k = ST_OUT;
        4'd8: k = ST_CLEAN;
        default: k = ST_DONE;
      endcase
    end else begin
      case (seg)
        4'd0: k = ST_SETUP;
        4'd1: k = ST_OUT;
        4'd2: k = ST_IN;
        4'd3: k = ST_STBY;
        default: k = ST_DONE;
      endcase
    end
    return k;
  endfunction

  // Left-aligned bit frame to shift out in an output segment.
  function automatic logic [MW_FRAME_W-1:0] seg_frame(
      input logic wr, input logic [MW_SEG_W-1:0] seg,
      input logic [MW_ADDR_W-1:0] addr, input logic [MW_DATA_W-1:0] data);
    logic [MW_FRAME_W-1:0] f;
    f = '0;
    if (!wr)                f[MW_FRAME_W-1 -: MW_CMD_W] = {OP_READ, addr};
    else if (seg == 4'd1)   f[MW_FRAME_W-1 -: 5] = OP_WEN;
    else if (seg == 4'd3)   f = {OP_WRITE, addr, data};
    else                    f[MW_FRAME_W-1 -: 5] = OP_WDIS;
    return f;
  endfunction

  function automatic logic [MW_CNT_W-1:0] seg_bits(input logic wr, input logic [MW_SEG_W-1:0] seg);
    return (wr && seg == 4'd3) ? MW_CNT_W'(MW_FRAME_W) : MW_CNT_W'(MW_CMD_W);
  endfunction

endpackage

// File: rtl/mw_phase_timer.sv
module mw_phase_timer #(
  parameter int unsigned PHASE_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned PH_W = $clog2(PHASE_CYC + 1);

  logic [PH_W-1:0] cnt_q;

  assign tick = run && (cnt_q == PH_W'(PHASE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  // R2: the phase counter never passes the end of a phase
  a_r2_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < PH_W'(PHASE_CYC));
endmodule

// File: rtl/mw_shift_reg.sv
module mw_shift_reg #(
  parameter int unsigned W     = 25,
  parameter int unsigned LOW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             shl,
  input  logic             shin,
  input  logic             din,
  output logic             msb,
  output logic [LOW_W-1:0] low
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_val;
    else if (shl)   sr_q <= {sr_q[W-2:0], 1'b0};
    else if (shin)  sr_q <= {sr_q[W-2:0], din};
  end

  assign msb = sr_q[W-1];
  assign low = sr_q[LOW_W-1:0];
endmodule

// File: rtl/mw_pin_drive.sv
module mw_pin_drive
  import mw_eeprom_pkg::*;
(
  input  mw_state_e  state,
  input  logic [1:0] sub,
  input  logic       msb,
  input  logic       idle_cs,
  input  logic       wr,
  output logic       cs,
  output logic       sk,
  output logic       di
);
  always_comb begin
    cs = 1'b1;
    sk = 1'b0;
    di = 1'b0;
    case (state)
      ST_IDLE:  cs = idle_cs;
      ST_SETUP: cs = (sub == 2'd0) ? idle_cs : 1'b1;
      ST_OUT:   begin di = msb; sk = (sub == 2'd1); end
      ST_IN:    sk = (sub == 2'd0);
      ST_STBY:  begin cs = sub[1]; sk = sub[1] ^ sub[0]; end
      ST_POLL:  cs = 1'b1;
      ST_CLEAN: begin cs = 1'b0; sk = (sub == 2'd1); end
      ST_DONE:  cs = ~wr;
      default:  cs = 1'b0;
    endcase
  end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
  import mw_eeprom_pkg::*;
#(
  parameter int unsigned PHASE_CYC = 5000,
  parameter int unsigned POLL_MAX  = 200
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [MW_ADDR_W-1:0] cmd_addr,
  input  logic [MW_DATA_W-1:0] cmd_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [MW_DATA_W-1:0] rd_data,
  output logic                 timeout,
  output logic                 ee_cs,
  output logic                 ee_sk,
  output logic                 ee_di,
  input  logic                 ee_do
);
  localparam int unsigned POLL_W = $clog2(POLL_MAX + 1);

  mw_state_e             state_q;
  logic [MW_SEG_W-1:0]   seg_q;
  logic [1:0]            sub_q;
  logic [MW_CNT_W-1:0]   bit_q, nbits_q;
  logic [POLL_W-1:0]     poll_q;
  logic                  wr_q, tmo_q, idle_cs_q;
  logic [MW_ADDR_W-1:0]  addr_q;
  logic [MW_DATA_W-1:0]  wdata_q;
  logic [1:0]            do_sync_q;

  // named internal events
  logic                  do_s, accept, run, tick, seg_end, shl, shin, load, msb;
  logic                  poll_hit, poll_expire;
  logic [MW_SEG_W-1:0]   nseg;
  mw_state_e             nkind;

  assign do_s   = do_sync_q[1];
  assign accept = (state_q == ST_IDLE) && cmd_valid;
  assign run    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign nseg   = seg_q + 1'b1;
  assign nkind  = seg_kind(wr_q, nseg);

  assign poll_hit    = tick && (state_q == ST_POLL) && do_s;
  assign poll_expire = tick && (state_q == ST_POLL) && !do_s && (poll_q == POLL_W'(POLL_MAX - 1));

  always_comb begin
    seg_end = 1'b0;
    case (state_q)
      ST_SETUP: seg_end = tick && (sub_q == 2'd1);
      ST_OUT:   seg_end = tick && (sub_q == 2'd2) && (bit_q == nbits_q - 1'b1);
      ST_IN:    seg_end = tick && (sub_q == 2'd1) && (bit_q == MW_CNT_W'(MW_DATA_W - 1));
      ST_STBY:  seg_end = tick && (sub_q == 2'd3);
      ST_POLL:  seg_end = poll_hit || poll_expire;
      ST_CLEAN: seg_end = tick && (sub_q == 2'd2);
      default:  seg_end = 1'b0;
    endcase
  end

  assign load = seg_end && (nkind == ST_OUT);
  assign shl  = tick && (state_q == ST_OUT) && (sub_q == 2'd2);
  assign shin = tick && (state_q == ST_IN) && (sub_q == 2'd0);

  mw_phase_timer #(.PHASE_CYC(PHASE_CYC)) timer_i (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick));

  mw_shift_reg #(.W(MW_FRAME_W), .LOW_W(MW_DATA_W)) shreg_i (
    .clk(clk), .rst_n(rst_n), .load(load),
    .load_val(seg_frame(wr_q, nseg, addr_q, wdata_q)),
    .shl(shl), .shin(shin), .din(do_s), .msb(msb), .low(rd_data));

  mw_pin_drive pins_i (
    .state(state_q), .sub(sub_q), .msb(msb), .idle_cs(idle_cs_q), .wr(wr_q),
    .cs(ee_cs), .sk(ee_sk), .di(ee_di));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) do_sync_q <= '0;
    else        do_sync_q <= {do_sync_q[0], ee_do};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; seg_q <= '0; sub_q <= '0; bit_q <= '0; nbits_q <= '0;
      poll_q <= '0; wr_q <= 1'b0; tmo_q <= 1'b0; idle_cs_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0;
    end else if (accept) begin
      state_q <= ST_SETUP; seg_q <= '0; sub_q <= '0; tmo_q <= 1'b0;
      wr_q <= cmd_write; addr_q <= cmd_addr; wdata_q <= cmd_wdata;
    end else if (state_q == ST_DONE) begin
      state_q   <= ST_IDLE;
      idle_cs_q <= ~wr_q;
    end else if (seg_end) begin
      state_q <= nkind; seg_q <= nseg; sub_q <= '0; bit_q <= '0; poll_q <= '0;
      nbits_q <= seg_bits(wr_q, nseg);
      if (poll_expire) tmo_q <= 1'b1;
    end else if (tick) begin
      case (state_q)
        ST_OUT: if (sub_q == 2'd2) begin sub_q <= '0; bit_q <= bit_q + 1'b1; end
                else sub_q <= sub_q + 1'b1;
        ST_IN:  if (sub_q == 2'd1) begin sub_q <= '0; bit_q <= bit_q + 1'b1; end
                else sub_q <= 2'd1;
        ST_POLL: poll_q <= poll_q + 1'b1;
        default: sub_q <= sub_q + 1'b1;
      endcase
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign timeout = tmo_q;

  // R2: data line is steady across a clock-high phase
  a_r2_di_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
  // R3: chip select never rises with data high
  a_r3_cs_rise_di_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> !ee_di);
  // R5: data line low while receiving, in standby and while polling
  a_r5_di_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IN || state_q == ST_STBY || state_q == ST_POLL) |-> !ee_di);
  // R8: poll count stays within its bound
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> (poll_q < POLL_W'(POLL_MAX)));
  // R9: timeout holds until a new command is taken
  a_r9_tmo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && !accept) |=> timeout);
  // R11: captured command is frozen while busy
  a_r11_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) && $stable(wr_q) && $stable(wdata_q)));
  // R12: completion is a single-cycle pulse followed by idle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R10: clock is low and select matches the command type at completion
  a_r10_done_pins: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ee_sk && !ee_di && (ee_cs == !wr_q)));
endmodule

// File: tb/mw_eeprom_master_tb_top.sv
module mw_eeprom_master_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PH   = 4;
  localparam int PMAX = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [5:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic busy, done, timeout, ee_cs, ee_sk, ee_di, ee_do;
  logic [15:0] rd_data;

  int n_checks = 0, n_errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom_master #(.PHASE_CYC(PH), .POLL_MAX(PMAX)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rd_data(rd_data), .timeout(timeout), .ee_cs(ee_cs), .ee_sk(ee_sk),
    .ee_di(ee_di), .ee_do(ee_do));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] init_word(input int a);
    return 16'(a * 16'h0B3D) ^ 16'h5AC3;
  endfunction
  // Phase totals restated from the sequence lists
  function automatic int read_phases();
    return 2 + 9 * 3 + 16 * 2 + 4;
  endfunction
  function automatic int write_phases(input int k);
    int p;
    p = (k > PMAX) ? PMAX : k;
    return 2 + 9 * 3 + 4 + 25 * 3 + 4 + p + 4 + 9 * 3 + 3;
  endfunction

  // ---------------- device model ----------------
  logic [15:0] dev_mem [64];
  logic [15:0] ref_mem [64];
  logic [1:0]  md = 2'd0;       // 0 receive, 1 transmit, 2 programming
  logic [31:0] rx_sr = '0;
  int rx_n = 0, tx_i = 0;
  logic [15:0] tx_word = '0;
  logic tx_bit = 1'b0, wen = 1'b0, pend = 1'b0, rdy = 1'b0;
  logic cs_d = 1'b0, sk_d = 1'b0;
  int n_ewen = 0, n_ewds = 0, n_commit = 0, n_read = 0;
  int cs_rise_skhi = 0, sk_rise_cslo = 0, viol_r3 = 0, viol_r5 = 0;
  int ready_at = -1, pc = 0;

  assign ee_do = (md == 2'd2) ? rdy : ((md == 2'd1) ? tx_bit : 1'b0);

  always @(ee_cs or ee_sk) begin
    if (ee_cs === 1'b1 && cs_d === 1'b0) begin
      if (ee_di) viol_r3++;
      if (ee_sk) cs_rise_skhi++;
      md = pend ? 2'd2 : 2'd0;
      pend = 1'b0; rx_n = 0; rx_sr = '0;
    end
    if (ee_sk === 1'b1 && sk_d === 1'b0) begin
      if (!ee_cs) sk_rise_cslo++;
      else if (md == 2'd0) begin
        rx_sr = {rx_sr[30:0], ee_di}; rx_n++;
        if (rx_n == 9) begin
          if (rx_sr[8:6] == 3'b110) begin
            md = 2'd1; tx_word = dev_mem[rx_sr[5:0]]; tx_i = 15; n_read++;
          end else if (rx_sr[8:0] == 9'b100110000) begin wen = 1'b1; n_ewen++; end
          else if (rx_sr[8:0] == 9'b100000000) begin wen = 1'b0; n_ewds++; end
        end
        if (rx_n == 25 && rx_sr[24:22] == 3'b101) begin
          if (wen) begin dev_mem[rx_sr[21:16]] = rx_sr[15:0]; n_commit++; end
          pend = 1'b1;
        end
      end else if (md == 2'd1) begin
        if (ee_di) viol_r5++;
        if (tx_i >= 0) begin tx_bit = tx_word[tx_i]; tx_i--; end
      end
    end
    cs_d = ee_cs; sk_d = ee_sk;
  end

  always @(negedge clk) begin
    if (md == 2'd2) begin pc++; if (pc == ready_at) rdy = 1'b1; end
    else begin pc = 0; rdy = 1'b0; end
  end

  // R2 pin monitor: DI steady while SK high
  int viol_r2 = 0;
  logic mon_sk = 1'b0, mon_di = 1'b0;
  always @(negedge clk) begin
    if (rst_n && ee_sk && mon_sk && ee_di != mon_di) viol_r2++;
    mon_sk = ee_sk; mon_di = ee_di;
  end

  // ---------------- command driver ----------------
  int lat, ndone, lingering;
  logic [15:0] got;
  bit got_tmo;

  task automatic run_op(input bit wr, input logic [5:0] a, input logic [15:0] d, input int k, input bit poke);
    ready_at = (k > PMAX) ? -1 : (1 + k) * PH + 1;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    lat = 0; ndone = 0; lingering = 0; got = '0; got_tmo = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (lat == 1) cmd_valid = 1'b0;
      if (poke && lat == 30) begin cmd_valid = 1'b1; cmd_write = ~wr; cmd_addr = ~a; end
      if (poke && lat == 31) cmd_valid = 1'b0;
      if (done) begin ndone++; got = rd_data; got_tmo = timeout; break; end
      if (lat > 5000) break;
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (done) ndone++;
      if (busy) lingering++;
    end
    if (wr) ref_mem[a] = d;
  endtask

  task automatic do_read(input logic [5:0] a, input bit poke);
    int r0, c0, s0;
    r0 = n_read; c0 = cs_rise_skhi; s0 = sk_rise_cslo;
    run_op(1'b0, a, '0, 0, poke);
    check(got == ref_mem[a], "R4 read data", got, ref_mem[a]);
    check(lat == read_phases() * PH + 1, "R4 read latency", lat, read_phases() * PH + 1);
    check(n_read == r0 + 1, "R4 read opcode seen once", n_read - r0, 1);
    check(cs_rise_skhi == c0 + 1 && sk_rise_cslo == s0 + 1, "R6 read standby", cs_rise_skhi - c0, 1);
    check(ndone == 1 && lingering == 0, "R12 single done", ndone, 1);
  endtask

  task automatic do_write(input logic [5:0] a, input logic [15:0] d, input int k, input bit poke);
    int e0, w0, m0, c0, s0;
    e0 = n_ewen; w0 = n_ewds; m0 = n_commit; c0 = cs_rise_skhi; s0 = sk_rise_cslo;
    run_op(1'b1, a, d, k, poke);
    check(lat == write_phases(k) * PH + 1, (k > PMAX) ? "R9 timeout latency" : "R8 write latency",
          lat, write_phases(k) * PH + 1);
    check(got_tmo == (k > PMAX), "R9 timeout flag", got_tmo, (k > PMAX));
    check(n_ewen == e0 + 1 && n_commit == m0 + 1 && n_ewds == w0 + 1 && !wen,
          "R7 enable-write-disable order", n_commit - m0, 1);
    check(cs_rise_skhi == c0 + 3, "R6 write standby count", cs_rise_skhi - c0, 3);
    check(sk_rise_cslo == s0 + 4, "R10 cleanup pulse", sk_rise_cslo - s0, 4);
    check(!ee_cs && !ee_sk && !ee_di, "R10 idle pins after write", {ee_cs, ee_sk, ee_di}, 0);
    check(ndone == 1 && lingering == 0, "R12 single done", ndone, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 64; i++) begin dev_mem[i] = init_word(i); ref_mem[i] = init_word(i); end
    repeat (3) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done, timeout} == 6'b0, "R1 pins in reset",
          {ee_cs, ee_sk, ee_di, busy, done, timeout}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({ee_cs, ee_sk, ee_di, busy, done, timeout} == 6'b0, "R1 idle after reset",
          {ee_cs, ee_sk, ee_di, busy, done, timeout}, 0);

    do_read(6'd0, 1'b0);
    do_read(6'd63, 1'b0);
    do_write(6'd63, 16'hFFFF, 1, 1'b0);
    do_read(6'd63, 1'b0);
    do_write(6'd0, 16'h0000, PMAX, 1'b0);
    do_read(6'd0, 1'b0);
    // R9: device never reports ready
    do_write(6'd17, 16'h8001, PMAX + 40, 1'b0);
    check(timeout == 1'b1, "R9 timeout held in idle", timeout, 1);
    do_read(6'd17, 1'b0);
    check(got_tmo == 1'b0 && timeout == 1'b0, "R9 timeout cleared by next command", timeout, 0);
    // R11: request while busy is ignored
    do_read(6'd5, 1'b1);
    check(n_commit == 3, "R11 no write from busy request", n_commit, 3);
    do_write(6'd9, 16'h3C5A, 3, 1'b1);
    check(n_read == 6, "R11 no read from busy request", n_read, 6);

    for (int i = 0; i < 24; i++) begin
      logic [5:0] a;
      a = 6'($urandom % 64);
      if ($urandom % 2) do_write(a, 16'($urandom), 1 + int'($urandom % PMAX), 1'b0);
      else do_read(a, 1'b0);
    end
    for (int i = 0; i < 4; i++) do_read(6'(i * 17), 1'b0);

    check(viol_r2 == 0, "R2 DI steady while SK high", viol_r2, 0);
    check(viol_r3 == 0, "R3 DI low at CS rise", viol_r3, 0);
    check(viol_r5 == 0, "R5 DI low while receiving", viol_r5, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule